// File: doc/BRIEF.md
# Configurable RAM Access Latency Sequencer

This block sits between a cache request pipeline and a synchronous tag or data RAM. It issues each request to the RAM and returns read data after a fixed latency. That latency is set at run time by three configuration inputs: a 3-bit access-time code, a setup-cycle bit and a requested number of register slices. The block works out two figures from them. The RAM latency is the number of cycles the RAM inputs stay applied to one access. The total latency is the RAM latency plus two cycles for every active slice.

Requests arrive on a valid/ready handshake. After it accepts a request, the block keeps the RAM address, enable, write flag and write data unchanged for the whole RAM latency window. It passes them through as many input slice registers as are active. It captures the RAM output at the last cycle of the window and returns it through the same number of output slice registers. The slices are pipeline stages only, so the rate at which accesses can be issued depends on the RAM latency alone.

A parameter selects tag mode or data mode, and each mode has its own caps on latency. A second parameter sets how many slice stages are built. Tag mode always builds one. Data mode builds one or two.

Top module: `ram_lat_seq`

## Requirements
- R1: With no slice active, the RAM latency is the code time plus one cycle when the setup bit is 1. The code time is 2 cycles for codes 0 and 1, 3 cycles for code 2, 4 cycles for code 3, and 5 cycles for codes 4 to 7. The RAM latency is never below 2.
- R2: Each active slice adds 2 cycles, one on each side of the RAM. The total latency equals the RAM latency plus twice the active slice count.
- R3: In tag mode (DATA_MODE=0) the total latency never exceeds 5. With one slice active, the RAM latency is limited to 3.
- R4: In data mode (DATA_MODE=1), with any slice active, the RAM latency is limited to 4. The total latency never exceeds 6 when MAX_SLICES=1, or 8 when MAX_SLICES=2.
- R5: A requested slice count above MAX_SLICES is treated as MAX_SLICES.
- R6: `req_ready` goes low in the cycle after a request is accepted. It returns high so that, while `req_valid` is held high, the next request is accepted exactly RAM-latency cycles after the previous one, whatever the slice count.
- R7: Each access holds `ram_en` high and keeps `ram_addr`, `ram_we` and `ram_wdata` unchanged for exactly RAM-latency consecutive cycles. These cycles begin once the request has passed through the active input slices.
- R8: For a read (`req_we`=0), `rd_valid` pulses for one cycle exactly total-latency cycles after the accepting clock edge. `rd_data` then carries the RAM word at the request address. A write (`req_we`=1) produces no `rd_valid` pulse.
- R9: The configuration inputs are sampled at the accepting clock edge. Changing them while an access is in flight does not alter that access's latency.
- R10: After reset, `req_ready` is 1 and both `rd_valid` and `ram_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_code | input | 3 | Access-time code |
| cfg_setup | input | 1 | Adds one setup cycle to the RAM latency |
| cfg_slices | input | 2 | Requested number of active register slices |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| ram_en | output | 1 | RAM enable, held for the access window |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, captured on the last window cycle |
| rd_valid | output | 1 | One-cycle read-data valid pulse |
| rd_data | output | DATA_W | Returned read data |

## Verification
The assertions assume three things about the inputs. First, the active slice count stays the same while any earlier access is still inside the slice pipeline. Second, the RAM returns `ram_rdata` combinationally from the address applied to it. Third, `rst_n` starts low. The stimulus meets the first condition by changing configuration only just after a request has been accepted. It then lets every in-flight access drain before it issues the next request. This still exercises the mid-flight configuration change of R9. Within one configuration, the requests are back-to-back bursts and randomly gapped mixed reads and writes. Consecutive accesses always go to different addresses, so each RAM window can be told apart at the pins.

// File: rtl/ram_lat_seq_pkg.sv
package ram_lat_seq_pkg;

   localparam int LAT_W = 4;

   // access time selected by the programmed code, before setup or caps
   function automatic logic [LAT_W-1:0] code_cycles(input logic [2:0] code);
      logic [LAT_W-1:0] c;
      case (code)
         3'd0, 3'd1: c = LAT_W'(2);
         3'd2:       c = LAT_W'(3);
         3'd3:       c = LAT_W'(4);
         default:    c = LAT_W'(5);
      endcase
      return c;
   endfunction

   // limit on the RAM portion once a slice is active
   function automatic int ram_cap_sliced(input bit data_mode);
      return data_mode ? 4 : 3;
   endfunction

   // limit on the whole load-to-data latency
   function automatic int total_cap(input bit data_mode, input int max_slices);
      return data_mode ? ((max_slices >= 2) ? 8 : 6) : 5;
   endfunction

endpackage

// File: rtl/ram_lat_seq_calc.sv
module ram_lat_seq_calc
   import ram_lat_seq_pkg::*;
#(
   parameter bit DATA_MODE  = 1'b1,
   parameter int MAX_SLICES = 2
) (
   input  logic [2:0]       code,
   input  logic             setup,
   input  logic [1:0]       slices_req,
   output logic [1:0]       n_eff,
   output logic [LAT_W-1:0] ram_lat
);

   localparam int              RAM_CAP = ram_cap_sliced(DATA_MODE);
   localparam int              TOT_CAP = total_cap(DATA_MODE, MAX_SLICES);
   localparam logic [1:0]      N_MAX   = 2'(MAX_SLICES);
   localparam logic [LAT_W-1:0] LIM_SL = LAT_W'(RAM_CAP);
   localparam logic [LAT_W-1:0] LIM_NS = LAT_W'(TOT_CAP);

   logic [LAT_W-1:0] raw;
   logic [LAT_W-1:0] lim;

   always_comb begin
      n_eff = (slices_req > N_MAX) ? N_MAX : slices_req;
      raw   = code_cycles(code) + LAT_W'(setup);
      // slice and setup outrank the code: the RAM share is clipped per slice state
      lim     = (n_eff != 2'd0) ? LIM_SL : LIM_NS;
      ram_lat = (raw > lim) ? lim : raw;
   end

endmodule

// File: rtl/ram_lat_seq_pipe.sv
module ram_lat_seq_pipe #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic [1:0]   sel,
   output logic [W-1:0] q
);

   logic [W-1:0] regs [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) regs[k] <= '0;
      end else begin
         regs[0] <= d;
         for (int k = 1; k < DEPTH; k++) regs[k] <= regs[k-1];
      end
   end

   // tap 0 is the bypass, tap k is the k-th register
   always_comb begin
      q = d;
      for (int k = 0; k < DEPTH; k++)
         if (sel == 2'(k + 1)) q = regs[k];
   end

endmodule

// File: rtl/ram_lat_seq_ctrl.sv
module ram_lat_seq_ctrl
   import ram_lat_seq_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   input  logic [LAT_W-1:0]  lat_cfg,
   input  logic [1:0]        n_cfg,
   output logic              hold_en,
   output logic              hold_we,
   output logic [ADDR_W-1:0] hold_addr,
   output logic [DATA_W-1:0] hold_wdata,
   output logic              hold_last,
   output logic [1:0]        n_act
);

   logic [LAT_W-1:0] cnt;
   logic             accept;

   assign req_ready = (cnt == '0);
   assign accept    = req_valid && req_ready;
   assign hold_last = hold_en && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         hold_en    <= 1'b0;
         hold_we    <= 1'b0;
         hold_addr  <= '0;
         hold_wdata <= '0;
         n_act      <= '0;
      end else if (accept) begin
         cnt        <= lat_cfg - LAT_W'(1);
         hold_en    <= 1'b1;
         hold_we    <= req_we;
         hold_addr  <= req_addr;
         hold_wdata <= req_wdata;
         n_act      <= n_cfg;
      end else if (cnt != '0) begin
         cnt <= cnt - LAT_W'(1);
      end else begin
         hold_en <= 1'b0;
      end
   end

endmodule

// File: rtl/ram_lat_seq.sv
module ram_lat_seq
   import ram_lat_seq_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter bit DATA_MODE  = 1'b1,
   parameter int MAX_SLICES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_code,
   input  logic              cfg_setup,
   input  logic [1:0]        cfg_slices,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   localparam int IN_W  = 3 + ADDR_W + DATA_W;
   localparam int OUT_W = 1 + DATA_W;

   generate
      if (!((DATA_MODE == 1'b0 && MAX_SLICES == 1) ||
            (DATA_MODE == 1'b1 && (MAX_SLICES == 1 || MAX_SLICES == 2)))) begin : g_bad_slices
         $error("ram_lat_seq: MAX_SLICES not supported in this mode");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ram_lat_seq: widths must be positive");
      end
   endgenerate

   logic [1:0]        n_eff;
   logic [LAT_W-1:0]  ram_lat;
   logic              hold_en, hold_we, hold_last;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_wdata;
   logic [1:0]        n_act;
   logic              pin_last;
   logic [IN_W-1:0]   pin_bus;
   logic              cap_v;
   logic [DATA_W-1:0] cap_d;

   ram_lat_seq_calc #(
      .DATA_MODE  (DATA_MODE),
      .MAX_SLICES (MAX_SLICES)
   ) u_calc (
      .code       (cfg_code),
      .setup      (cfg_setup),
      .slices_req (cfg_slices),
      .n_eff      (n_eff),
      .ram_lat    (ram_lat)
   );

   ram_lat_seq_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_we     (req_we),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_ready  (req_ready),
      .lat_cfg    (ram_lat),
      .n_cfg      (n_eff),
      .hold_en    (hold_en),
      .hold_we    (hold_we),
      .hold_addr  (hold_addr),
      .hold_wdata (hold_wdata),
      .hold_last  (hold_last),
      .n_act      (n_act)
   );

   // slice half in front of the RAM
   ram_lat_seq_pipe #(
      .W     (IN_W),
      .DEPTH (MAX_SLICES)
   ) u_in_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hold_en, hold_we, hold_last, hold_addr, hold_wdata}),
      .sel   (n_act),
      .q     (pin_bus)
   );

   assign {ram_en, ram_we, pin_last, ram_addr, ram_wdata} = pin_bus;

   // capture RAM output on the final window cycle of a read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_v <= 1'b0;
         cap_d <= '0;
      end else begin
         cap_v <= ram_en && !ram_we && pin_last;
         if (ram_en && !ram_we && pin_last) cap_d <= ram_rdata;
      end
   end

   // slice half behind the RAM
   ram_lat_seq_pipe #(
      .W     (OUT_W),
      .DEPTH (MAX_SLICES)
   ) u_out_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cap_v, cap_d}),
      .sel   (n_act),
      .q     ({rd_valid, rd_data})
   );

endmodule

// File: rtl/ram_lat_seq_chk.sv
module ram_lat_seq_chk
   import ram_lat_seq_pkg::*;
#(
   parameter bit DATA_MODE  = 1'b1,
   parameter int MAX_SLICES = 2,
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              ram_en,
   input logic              ram_we,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [DATA_W-1:0] ram_wdata,
   input logic              pin_last,
   input logic              rd_valid,
   input logic [1:0]        n_eff,
   input logic [LAT_W-1:0]  ram_lat
);

   localparam int TOT_CAP = total_cap(DATA_MODE, MAX_SLICES);

   logic [LAT_W:0] whole;
   assign whole = (LAT_W+1)'(ram_lat) + (LAT_W+1)'({n_eff, 1'b0});

   // R10
   rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req_ready && !rd_valid && !ram_en));

   // R6
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R7
   pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && !pin_last) |=> (ram_en && $stable(ram_addr) && $stable(ram_we) && $stable(ram_wdata)));

   // R8
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R1
   ram_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_lat >= LAT_W'(2));

   // R3 R4
   total_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(whole) <= TOT_CAP);

   // R5
   slice_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(n_eff) <= MAX_SLICES);

endmodule

bind ram_lat_seq ram_lat_seq_chk #(
   .DATA_MODE  (DATA_MODE),
   .MAX_SLICES (MAX_SLICES),
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .ram_en    (ram_en),
   .ram_we    (ram_we),
   .ram_addr  (ram_addr),
   .ram_wdata (ram_wdata),
   .pin_last  (pin_last),
   .rd_valid  (rd_valid),
   .n_eff     (n_eff),
   .ram_lat   (ram_lat)
);

// File: tb/sim_ram_lat_seq.sv
module sim_lane #(
   parameter bit DATA_MODE  = 1'b1,
   parameter int MAX_SLICES = 2,
   parameter int SEED       = 1
) (
   input  logic clk,
   input  logic rst_n,
   output int   n_chk,
   output int   n_bad,
   output logic done
);

   localparam int AW = 6;
   localparam int DW = 32;

   logic [2:0]    cfg_code;
   logic          cfg_setup;
   logic [1:0]    cfg_slices;
   logic          req_valid, req_ready, req_we;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          ram_en, ram_we;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata, ram_rdata;
   logic          rd_valid;
   logic [DW-1:0] rd_data;

   ram_lat_seq #(
      .ADDR_W (AW), .DATA_W (DW), .DATA_MODE (DATA_MODE), .MAX_SLICES (MAX_SLICES)
   ) u0 (
      .clk (clk), .rst_n (rst_n),
      .cfg_code (cfg_code), .cfg_setup (cfg_setup), .cfg_slices (cfg_slices),
      .req_valid (req_valid), .req_ready (req_ready), .req_we (req_we),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .ram_en (ram_en), .ram_we (ram_we), .ram_addr (ram_addr),
      .ram_wdata (ram_wdata), .ram_rdata (ram_rdata),
      .rd_valid (rd_valid), .rd_data (rd_data)
   );

   // RAM model
   logic [DW-1:0] mem [64];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= '0;
      end else if (ram_en && ram_we) begin
         mem[ram_addr] <= ram_wdata;
      end
   end
   assign ram_rdata = mem[ram_addr];

   // reference model
   function automatic int ref_n(input int sl);
      return (sl > MAX_SLICES) ? MAX_SLICES : sl;
   endfunction

   function automatic int ref_raw(input int code, input int setup);
      int t;
      if (code < 2) t = 2;
      else if (code > 4) t = 5;
      else t = code + 1;
      return t + setup;
   endfunction

   function automatic int ref_ram(input int code, input int setup, input int sl);
      int r, n;
      r = ref_raw(code, setup);
      n = ref_n(sl);
      if (DATA_MODE) begin
         if (n > 0 && r > 4) r = 4;
      end else begin
         if (n > 0 && r > 3) r = 3;
         if (r > 5) r = 5;
      end
      return r;
   endfunction

   function automatic string ref_tag(input int code, input int setup, input int sl);
      if (sl > MAX_SLICES) return "R5";
      if (ref_ram(code, setup, sl) < ref_raw(code, setup)) return DATA_MODE ? "R4" : "R3";
      if (sl > 0) return "R2";
      return "R1";
   endfunction

   int cyc;
   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else cyc <= cyc + 1;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // scoreboard state
   int            exp_cyc [$];
   logic [DW-1:0] exp_dat [$];
   string         exp_tag [$];
   int            exp_cfg [$];
   int            lat_q [$];
   logic [DW-1:0] ref_mem [64];
   bit            rst_seen, cont, have_prev;
   int            prev_acc, prev_lat;
   bit            p_en, p_we;
   logic [AW-1:0] p_addr;
   logic [DW-1:0] p_wd;
   int            run_len;

   initial begin
      n_chk = 0;
      n_bad = 0;
      rst_seen = 0;
      cont = 0;
      have_prev = 0;
      p_en = 0;
      run_len = 0;
      for (int i = 0; i < 64; i++) ref_mem[i] = '0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!rst_seen) begin
            rst_seen = 1;
            // R10 reset state at the ports
            chk(req_ready && !rd_valid && !ram_en, "R10 reset state",
                {req_ready, rd_valid, ram_en}, 3'b100);
         end

         // R8 read return timing and data, R9 latched configuration
         if (rd_valid) begin
            if (exp_cyc.size() == 0) begin
               chk(0, "R8 unexpected rd_valid", 1, 0);
            end else begin
               int    ec, cf;
               string tg;
               logic [DW-1:0] ed;
               ec = exp_cyc.pop_front();
               ed = exp_dat.pop_front();
               tg = exp_tag.pop_front();
               cf = exp_cfg.pop_front();
               if (cf != int'({cfg_code, cfg_setup, cfg_slices})) tg = {tg, " R9"};
               chk(cyc == ec, {tg, " R8 read latency"}, cyc, ec);
               chk(rd_data == ed, "R8 read data", rd_data, ed);
            end
         end

         // R7 window length and pin stability
         begin
            bit chg;
            chg = ram_en && p_en &&
                  (ram_addr != p_addr || ram_we != p_we || ram_wdata != p_wd);
            if (p_en && (!ram_en || chg)) begin
               if (lat_q.size() == 0) chk(0, "R7 window without request", run_len, 0);
               else begin
                  int el;
                  el = lat_q.pop_front();
                  chk(run_len == el, "R7 window length", run_len, el);
               end
            end
            if (ram_en && (!p_en || chg)) run_len = 1;
            else if (ram_en) run_len++;
            p_en = ram_en; p_we = ram_we; p_addr = ram_addr; p_wd = ram_wdata;
         end

         // acceptance: R6 spacing, push expectations
         if (req_valid && req_ready) begin
            int acc, c, s, sl, rl;
            acc = cyc + 1;
            c  = int'(cfg_code);
            s  = int'(cfg_setup);
            sl = int'(cfg_slices);
            rl = ref_ram(c, s, sl);
            if (have_prev) begin
               if (cont) chk(acc - prev_acc == prev_lat, "R6 back-to-back spacing",
                             acc - prev_acc, prev_lat);
               else chk(acc - prev_acc >= prev_lat, "R6 minimum spacing",
                        acc - prev_acc, prev_lat);
            end
            lat_q.push_back(rl);
            if (req_we) begin
               ref_mem[req_addr] = req_wdata;
            end else begin
               exp_cyc.push_back(acc + rl + 2 * ref_n(sl));
               exp_dat.push_back(ref_mem[req_addr]);
               exp_tag.push_back(ref_tag(c, s, sl));
               exp_cfg.push_back(int'({cfg_code, cfg_setup, cfg_slices}));
            end
            have_prev = 1;
            prev_acc  = acc;
            prev_lat  = rl;
            cont      = 1;
         end else if (!req_valid) begin
            cont = 0;
         end
      end
   end

   // driver: inputs change 1 ns after a rising edge
   logic [AW-1:0] last_addr;

   task automatic send(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_valid = 1'b1;
      req_we    = we;
      req_addr  = a;
      req_wdata = d;
      last_addr = a;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int g);
      req_valid = 1'b0;
      for (int i = 0; i < g; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic drain();
      req_valid = 1'b0;
      while (exp_cyc.size() != 0 || lat_q.size() != 0 || ram_en) begin
         @(posedge clk);
         #1;
      end
      idle(2);
   endtask

   function automatic logic [AW-1:0] pick_addr();
      logic [AW-1:0] a;
      a = AW'($urandom);
      if (a == last_addr) a = a ^ AW'(1);
      return a;
   endfunction

   initial begin
      done       = 1'b0;
      req_valid  = 1'b0;
      req_we     = 1'b0;
      req_addr   = '0;
      req_wdata  = '0;
      cfg_code   = 3'd0;
      cfg_setup  = 1'b0;
      cfg_slices = 2'd0;
      last_addr  = '1;
      void'($urandom(SEED));
      @(posedge rst_n);
      @(posedge clk);
      #1;
      // 64 exhaustive configurations, then random ones
      for (int idx = 0; idx < 84; idx++) begin
         logic [AW-1:0] base;
         base = pick_addr();
         for (int k = 0; k < 3; k++) begin
            logic [AW-1:0] ba;
            ba = base + AW'(k);
            if (ba == last_addr) ba = ba ^ AW'(1);
            send(1'b0, ba, DW'($urandom));
         end
         for (int k = 0; k < 4; k++) begin
            int g;
            g = $urandom % 3;
            if (g != 0) idle(g);
            send(1'(($urandom % 2)), pick_addr(), DW'($urandom));
         end
         // R9: configuration moves while the last access is still in flight
         if (idx + 1 < 64) begin
            logic [5:0] nx;
            nx = 6'(idx + 1);
            cfg_code   = nx[2:0];
            cfg_setup  = nx[3];
            cfg_slices = nx[5:4];
         end else begin
            cfg_code   = 3'($urandom);
            cfg_setup  = 1'($urandom);
            cfg_slices = 2'($urandom);
         end
         drain();
      end
      done = 1'b1;
   end

endmodule

module sim_ram_lat_seq;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   c_d, b_d, c_t, b_t;
   logic d_d, d_t;

   always #5 clk = ~clk;

   sim_lane #(.DATA_MODE(1'b1), .MAX_SLICES(2), .SEED(11)) lane_data (
      .clk (clk), .rst_n (rst_n), .n_chk (c_d), .n_bad (b_d), .done (d_d)
   );

   sim_lane #(.DATA_MODE(1'b0), .MAX_SLICES(1), .SEED(23)) lane_tag (
      .clk (clk), .rst_n (rst_n), .n_chk (c_t), .n_bad (b_t), .done (d_t)
   );

   initial begin
      int w, tot, bad;
      w = 0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      while (!(d_d && d_t) && w < 150000) begin
         @(posedge clk);
         w++;
      end
      #1;
      tot = c_d + c_t;
      bad = b_d + b_t;
      if (!(d_d && d_t)) begin
         tot++;
         bad++;
         $display("FAIL R8 watchdog expired actual=%0d expected=%0d", w, 150000);
      end
      $display("== %0d vectors applied, %0d miscompares ==", tot, bad);
      $finish;
   end

endmodule